// File: doc/BRIEF.md
# EPROM Bus-Mode Decoder with Autoselect

This block is the control-side behavioural model of a 16-bit UV-erasable read-only memory. Each cycle it looks at its inputs and picks one of seven bus modes: read, output disable, standby, program, program verify, program inhibit or identification. The inputs are chip enable, output enable, the program strobe, a flag for a raised programming supply and a flag for a high voltage on address bit 9.

The data bus is modelled as a data vector plus an output-enable flag. When the flag is low the bus is high-impedance and the data vector is zero. The storage array is a small register array indexed by the low address bits.

Programming can only clear bits. The incoming word is ANDed into the addressed location on a rising clock edge. An erase input, and reset, return every word to all ones.

In identification mode the block returns a manufacturer byte or a device byte, chosen by address bit 0. The low seven bits of each byte are parameters, and bit 7 is generated so that every byte has odd parity.

Top module: `eprom_mode_dec`

## Requirements
- R1: `dq_oe` is 1 only when `ce_n` and `oe_n` are both 0. Whenever `dq_oe` is 0, `dq_out` is all zeros.
- R2: With `vpp_hi`=0 and `ce_n`=1, `mode` is 2 (standby) and `dq_oe` is 0, whatever `oe_n`, `pgm_n` and `a_hv` are.
- R3: With `vpp_hi`=0, `ce_n`=0, `oe_n`=0 and no identification request, `mode` is 0 (read) and `dq_out` is the word stored at `addr[3:0]`.
- R4: With `vpp_hi`=0, `ce_n`=0, `oe_n`=0, `a_hv`=1, and every address bit other than bits 0 and 9 at 0, `mode` is 6 (identify). `dq_out[7:0]` is the manufacturer byte when `addr[0]`=0 and the device byte when `addr[0]`=1, and `dq_out[15:8]` is 0. If any other address bit is 1, the access is a plain read.
- R5: Both identifier bytes carry the 7-bit parameter value in bits 6:0, and bit 7 is set so that the byte has an odd number of ones.
- R6: With `vpp_hi`=1, `ce_n`=0 and `pgm_n`=0, `mode` is 3 (program) and `dq_oe` is 0. At the next rising edge, the word at `addr[3:0]` becomes its old value AND `din`.
- R7: With `vpp_hi`=1 and `ce_n`=1, `mode` is 5 (inhibit), `dq_oe` is 0, and no word changes, even when `pgm_n` is 0.
- R8: With `vpp_hi`=1, `ce_n`=0 and `pgm_n`=1, `mode` is 4 (verify) and the stored word is driven when `oe_n`=0. When `oe_n`=1, `mode` is 1 (output disable).
- R9: With `vpp_hi`=0, `ce_n`=0 and `oe_n`=1, `mode` is 1 (output disable) and `dq_oe` is 0.
- R10: `erase`=1 at a rising edge sets every word to 16'hFFFF and takes priority over programming. Reset leaves the array in the same all-ones state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; fills the array with ones |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| pgm_n | input | 1 | Program strobe, active low |
| vpp_hi | input | 1 | Programming supply present |
| a_hv | input | 1 | High voltage present on address bit 9 |
| erase | input | 1 | Sets the whole array to ones at the clock edge |
| addr | input | 10 | Word address |
| din | input | 16 | Word to program |
| dq_out | output | 16 | Data driven onto the bus (zero when not driven) |
| dq_oe | output | 1 | Bus driver enable; 0 means high-impedance |
| mode | output | 3 | Decoded mode code (0 read, 1 output disable, 2 standby, 3 program, 4 verify, 5 inhibit, 6 identify) |

## Verification
The assertions assume the decoded controls are stable across the rising edge at which a program or erase takes effect. The bench meets this by changing every input only on the falling edge.

The checks on the bus relate `mode` and the enables within the same cycle. They therefore take for granted that the high-voltage flags are plain levels, with no ordering among them.

The stimulus first walks through every mode deliberately, including identification requests that have a stray address bit set and a program strobe under inhibit. It then applies random control combinations with addresses biased toward the identification pattern and with only occasional erases.

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec #(
  parameter int DW = 16,
  parameter int AW = 10,
  parameter int IDXW = 4,
  parameter int HVBIT = 9,
  parameter logic [6:0] MFR_ID = 7'h01,
  parameter logic [6:0] DEV_ID = 7'h0C
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          pgm_n,
  input  logic          vpp_hi,
  input  logic          a_hv,
  input  logic          erase,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic [2:0]    mode
);
  localparam int DEPTH = 1 << IDXW;
  localparam logic [2:0] M_READ = 3'd0, M_ODIS = 3'd1, M_STBY = 3'd2, M_PROG = 3'd3,
                         M_VRFY = 3'd4, M_INHB = 3'd5, M_IDEN = 3'd6;
  localparam logic [AW-1:0] ID_MASK = ~((AW'(1) << HVBIT) | AW'(1));
  localparam logic [7:0] MFR_CODE = {~^MFR_ID, MFR_ID};
  localparam logic [7:0] DEV_CODE = {~^DEV_ID, DEV_ID};

  logic [DW-1:0] mem [DEPTH];
  logic [IDXW-1:0] idx;
  logic id_req;

  assign idx = addr[IDXW-1:0];
  assign id_req = a_hv && ((addr & ID_MASK) == '0);

  always_comb begin
    if (vpp_hi) begin
      if (ce_n)       mode = M_INHB;
      else if (!pgm_n) mode = M_PROG;
      else if (!oe_n) mode = M_VRFY;
      else            mode = M_ODIS;
    end else begin
      if (ce_n)       mode = M_STBY;
      else if (oe_n)  mode = M_ODIS;
      else if (id_req) mode = M_IDEN;
      else            mode = M_READ;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || erase) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (mode == M_PROG) begin
      mem[idx] <= mem[idx] & din;
    end
  end

  always_comb begin
    case (mode)
      M_READ, M_VRFY: dq_out = mem[idx];
      M_IDEN:         dq_out = DW'(addr[0] ? DEV_CODE : MFR_CODE);
      default:        dq_out = '0;
    endcase
  end

  assign dq_oe = (mode == M_READ) || (mode == M_VRFY) || (mode == M_IDEN);
endmodule

// File: rtl/eprom_mode_dec_chk.sv
module eprom_mode_dec_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          ce_n,
  input logic          oe_n,
  input logic          vpp_hi,
  input logic [DW-1:0] dq_out,
  input logic          dq_oe,
  input logic [2:0]    mode
);
  AST_DRIVE_NEEDS_ENABLES: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> (!ce_n && !oe_n)); // R1
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !dq_oe |-> (dq_out == '0)); // R1
  AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (rst)
    (!vpp_hi && ce_n) |-> (mode == 3'd2 && !dq_oe)); // R2
  AST_ID_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd6) |-> (dq_out[DW-1:8] == '0)); // R4
  AST_ID_ODD_PARITY: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd6) |-> ($countones(dq_out[7:0]) % 2 == 1)); // R5
  AST_PROG_HIZ: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd3) |-> !dq_oe); // R6
  AST_INHIBIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (vpp_hi && ce_n) |-> (mode == 3'd5 && !dq_oe)); // R7
endmodule

bind eprom_mode_dec eprom_mode_dec_chk #(.DW(DW)) u_chk (.*);

// File: tb/eprom_mode_dec_tb.sv
module eprom_mode_dec_tb;
  logic clk = 0;
  logic rst = 1;
  logic ce_n = 1, oe_n = 1, pgm_n = 1, vpp_hi = 0, a_hv = 0, erase = 0;
  logic [9:0] addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dq_out;
  logic dq_oe;
  logic [2:0] mode;

  int checks = 0, fails = 0;
  logic [15:0] ref_mem [16];

  always #2 clk = ~clk;

  eprom_mode_dec u_dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n), .vpp_hi(vpp_hi),
    .a_hv(a_hv), .erase(erase), .addr(addr), .din(din),
    .dq_out(dq_out), .dq_oe(dq_oe), .mode(mode)
  );

  function automatic logic [7:0] id_byte(input logic [6:0] v);
    int n = 0;
    for (int i = 0; i < 7; i++) n += v[i];
    return {(n % 2 == 0), v};
  endfunction

  function automatic int exp_mode();
    if (vpp_hi) begin
      if (ce_n) return 5;
      if (!pgm_n) return 3;
      return oe_n ? 1 : 4;
    end
    if (ce_n) return 2;
    if (oe_n) return 1;
    if (a_hv && addr[8:1] == 0) return 6;
    return 0;
  endfunction

  function automatic string tag_of(input int m);
    case (m)
      0: return "R3"; 1: return "R9"; 2: return "R2"; 3: return "R6";
      4: return "R8"; 5: return "R7"; default: return "R4";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic o, input logic p, input logic v,
                      input logic h, input logic e, input logic [9:0] a, input logic [15:0] d);
    int m;
    logic [15:0] ed;
    @(negedge clk);
    ce_n = c; oe_n = o; pgm_n = p; vpp_hi = v; a_hv = h; erase = e; addr = a; din = d;
    #1;
    m = exp_mode();
    if (m == 0 || m == 4) ed = ref_mem[a[3:0]];
    else if (m == 6) ed = {8'h00, a[0] ? id_byte(7'h0C) : id_byte(7'h01)};
    else ed = 16'h0000;
    check(tag_of(m), "mode", {13'd0, mode}, 16'(m));
    check("R1", "dq_oe", {15'd0, dq_oe}, {15'd0, (m == 0 || m == 4 || m == 6)});
    check(m == 6 ? "R5" : tag_of(m), "dq_out", dq_out, ed);
    if (e) begin
      for (int i = 0; i < 16; i++) ref_mem[i] = 16'hFFFF;
    end else if (m == 3) begin
      ref_mem[a[3:0]] = ref_mem[a[3:0]] & d;
    end
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) ref_mem[i] = 16'hFFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R10 reset state: all ones
    step(0, 0, 1, 0, 0, 0, 10'd3, 16'h0);
    // R2 standby with oe low
    step(1, 0, 0, 0, 1, 0, 10'd5, 16'h0);
    // R6 program two words, R3 read back
    step(0, 1, 0, 1, 0, 0, 10'd5, 16'hA5F0);
    step(0, 0, 0, 1, 0, 0, 10'd5, 16'h0FFF);
    step(0, 0, 1, 0, 0, 0, 10'd5, 16'h0);
    // R8 verify and output disable under vpp
    step(0, 0, 1, 1, 0, 0, 10'd5, 16'h0);
    step(0, 1, 1, 1, 0, 0, 10'd5, 16'h0);
    // R7 inhibit with strobe low, then read unchanged
    step(1, 0, 0, 1, 0, 0, 10'd7, 16'h0000);
    step(0, 0, 1, 0, 0, 0, 10'd7, 16'h0);
    // R9 output disable
    step(0, 1, 1, 0, 0, 0, 10'd7, 16'h0);
    // R4 R5 identification bytes, with bit 9 set or clear
    step(0, 0, 1, 0, 1, 0, 10'h000, 16'h0);
    step(0, 0, 1, 0, 1, 0, 10'h201, 16'h0);
    // R4 stray address bit gives a plain read
    step(0, 0, 1, 0, 1, 0, 10'h005, 16'h0);
    // R10 erase wins over program
    step(0, 0, 0, 1, 0, 1, 10'd5, 16'h0000);
    step(0, 0, 1, 0, 0, 0, 10'd5, 16'h0);
    for (int n = 0; n < 600; n++) begin
      logic [9:0] a;
      a = 10'($urandom);
      if ($urandom % 2 == 0) a = {a[9], 8'd0, a[0]};
      step($urandom % 4 == 0, 1'($urandom), 1'($urandom), $urandom % 3 == 0,
           1'($urandom), $urandom % 40 == 0, a, 16'($urandom | $urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule